// File: doc/BRIEF.md
# Display Panel Power and Enable Sequencer

This block steps a small OLED panel through its life cycle: it turns the panel's supplies on and off in the required order, it releases and re-asserts the panel reset with fixed waits between the steps, and it streams the configuration and mode-change commands to an external command writer. Four single-cycle requests (prepare, enable, disable, unprepare) and a brightness-level update drive it. It keeps two flags, prepared and enabled. A request that would only repeat the current state is dropped. While a sequence runs the block reports busy and ignores every new request.

Commands leave the block one byte at a time on a valid/ready stream. The first byte of a command is the opcode (`wr_dc` low). The parameter bytes follow with `wr_dc` high, and `wr_last` marks the final byte. After that byte the block waits for the writer's `wr_done` pulse, whose `wr_err` bit reports a failed command. All waits are counted in clock cycles from a cycles-per-millisecond parameter. Gamma bytes come from a small computed ROM that is indexed by brightness level and byte position.

Top module: `panel_seq_ctrl`

## Requirements
- R1: After reset, both supply enables are low, `panel_rst` is high, and `bl_en`, `prepared`, `enabled`, `busy` and `wr_valid` are low.
- R2: A prepare request first raises both supply enables together. After 25 ms `panel_rst` goes low, and after another 120 ms the first command byte appears. Both supply enables always have the same value.
- R3: Prepare sends, in this order: 0xF8 (14 parameters), 0xF2 (5), 0xF7 (3), 0xFA with the 22 gamma bytes of the current level, 0xFA with the one parameter 0x01, 0xF6 (3), 0xB1 (1) and 0x11 (no parameters). It then sets `prepared`. Each configuration parameter at position i (1-based) equals opcode XOR (i*0x13) mod 256.
- R4: A prepare request while prepared changes nothing and starts no sequence.
- R5: If the writer reports an error on any prepare command, the remaining commands are skipped. `panel_rst` rises, both supplies drop 120 ms later, and `prepared` stays low.
- R6: When prepared and not enabled, an enable request sends 0x29 and then sets `bl_en` and `enabled`. Enable is ignored when already enabled or not prepared.
- R7: When enabled, a disable request drops `bl_en` at once, sends 0x10, then waits 200 ms before it clears `enabled`.
- R8: The brightness level is 0 to 10 and is 10 after reset. A valid update stores the level. When prepared, it also sends 0xFA followed by 22 gamma bytes, where byte i = (32 + 7*i + 11*level) mod 256, and then sends 0xFA 0x01. Levels 11 to 15 are ignored.
- R9: When not prepared, an unprepare request is ignored. Otherwise `panel_rst` and `bl_en` change at once, supplies drop 120 ms later, and both flags clear.
- R10: Requests that arrive while `busy` is high have no effect.
- R11: A presented byte holds its value until `wr_ready` takes it. `wr_dc` is low only on opcode bytes. No byte of the next command is presented before `wr_done`.
- R12: Among simultaneous eligible requests, the priority order is unprepare, disable, prepare, enable, brightness. Only the winner acts.
- R13: A writer error ends the current sequence, so the commit after a failed gamma write is not sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_prepare | input | 1 | Power-up and init request pulse |
| req_enable | input | 1 | Display-on request pulse |
| req_disable | input | 1 | Display-off request pulse |
| req_unprepare | input | 1 | Power-down request pulse |
| lvl_set | input | 1 | Brightness update strobe |
| lvl_value | input | 4 | Requested brightness level |
| sup_en | output | 2 | Supply enables, both rails |
| panel_rst | output | 1 | Panel reset, active high |
| bl_en | output | 1 | Backlight enable |
| prepared | output | 1 | Panel powered and initialised |
| enabled | output | 1 | Display switched on |
| busy | output | 1 | A sequence is running |
| wr_valid | output | 1 | Command byte valid |
| wr_byte | output | 8 | Command byte |
| wr_dc | output | 1 | 0 = opcode, 1 = parameter |
| wr_last | output | 1 | Final byte of this command |
| wr_ready | input | 1 | Writer accepts the byte |
| wr_done | input | 1 | Writer finished the command |
| wr_err | input | 1 | Writer error, valid with wr_done |

## Verification
Every brightness level from 0 to 10 is swept with the panel prepared, and each emitted gamma byte is compared against the arithmetic rule. This separates a wrong level index from a wrong position index in the ROM. The out-of-range levels 11 to 15 are also swept to confirm that nothing is sent. The first prepare runs with a writer that stalls on every third cycle and later ones run with a writer that never stalls, which shows that held bytes are neither repeated nor lost. Requests are replayed in each flag state, issued together, and issued during a running sequence, and writer errors are injected during init and during a gamma write, so that drop rules, priority and early termination each show up in the command log and the supply and reset timestamps.

// File: rtl/panel_seq_pkg.sv
`timescale 1ns/1ps
// Shared types and command tables for the panel sequencer.
// Assumes: at most 8 steps per program and at most 31 parameters per command.
package panel_seq_pkg;

    localparam int GAMMA_LEVELS   = 11;
    localparam int GAMMA_NPARAM   = 22;
    localparam int LVL_W          = $clog2(GAMMA_LEVELS);
    localparam int POS_W          = $clog2(GAMMA_NPARAM + 1);
    localparam int STEP_W         = 3;
    localparam int GAMMA_BASE     = 32;
    localparam int GAMMA_POS_INC  = 7;
    localparam int GAMMA_LVL_INC  = 11;

    localparam logic [7:0] OP_GAMMA       = 8'hFA;
    localparam logic [7:0] OP_EXIT_SLEEP  = 8'h11;
    localparam logic [7:0] OP_ENTER_SLEEP = 8'h10;
    localparam logic [7:0] OP_DISPLAY_ON  = 8'h29;
    localparam logic [7:0] GAMMA_COMMIT   = 8'h01;

    typedef enum logic [1:0] {PRG_INIT, PRG_ON, PRG_SLEEP, PRG_GAMMA} prog_e;
    typedef enum logic [1:0] {PK_CFG, PK_GAMMA, PK_COMMIT} pkind_e;

    typedef struct packed {
        logic [7:0]       opcode;
        logic [POS_W-1:0] nparam;
        pkind_e           kind;
        logic             last;
    } step_t;

    // Describe one command step of a program.
    function automatic step_t step_lookup(prog_e prog, logic [STEP_W-1:0] idx);
        step_t s;
        s = '{OP_EXIT_SLEEP, POS_W'(0), PK_CFG, 1'b1};
        case (prog)
            PRG_INIT: begin
                case (idx)
                    3'd0: s = '{8'hF8, POS_W'(14), PK_CFG, 1'b0};
                    3'd1: s = '{8'hF2, POS_W'(5), PK_CFG, 1'b0};
                    3'd2: s = '{8'hF7, POS_W'(3), PK_CFG, 1'b0};
                    3'd3: s = '{OP_GAMMA, POS_W'(GAMMA_NPARAM), PK_GAMMA, 1'b0};
                    3'd4: s = '{OP_GAMMA, POS_W'(1), PK_COMMIT, 1'b0};
                    3'd5: s = '{8'hF6, POS_W'(3), PK_CFG, 1'b0};
                    3'd6: s = '{8'hB1, POS_W'(1), PK_CFG, 1'b0};
                    default: s = '{OP_EXIT_SLEEP, POS_W'(0), PK_CFG, 1'b1};
                endcase
            end
            PRG_ON:    s = '{OP_DISPLAY_ON, POS_W'(0), PK_CFG, 1'b1};
            PRG_SLEEP: s = '{OP_ENTER_SLEEP, POS_W'(0), PK_CFG, 1'b1};
            default: begin
                if (idx == '0) s = '{OP_GAMMA, POS_W'(GAMMA_NPARAM), PK_GAMMA, 1'b0};
                else           s = '{OP_GAMMA, POS_W'(1), PK_COMMIT, 1'b1};
            end
        endcase
        return s;
    endfunction

    // Configuration parameter value for a given opcode and 1-based position.
    function automatic logic [7:0] cfg_param(logic [7:0] op, logic [POS_W-1:0] pos);
        logic [7:0] mult;
        mult = 8'(pos) * 8'h13;
        return op ^ mult;
    endfunction

endpackage

// File: rtl/panel_ms_timer.sv
`timescale 1ns/1ps
// Down-counting delay timer. A go pulse loads a cycle count. fire is high
// in the last counted cycle. Assumes load is at least 1.
module panel_ms_timer #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             go,
    input  logic [CNT_W-1:0] load,
    output logic             fire
);

    logic [CNT_W-1:0] cnt_q;
    logic             run_q;

    assign fire = run_q && (cnt_q == CNT_W'(1));

    // Load on go, then count down and stop after the firing cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            run_q <= 1'b0;
        end else if (go) begin
            cnt_q <= load;
            run_q <= 1'b1;
        end else if (run_q) begin
            cnt_q <= cnt_q - CNT_W'(1);
            if (fire) run_q <= 1'b0;
        end
    end

endmodule

// File: rtl/panel_gamma_rom.sv
`timescale 1ns/1ps
// Computed gamma table indexed by level and 1-based byte position.
// Out-of-range indices read as zero.
module panel_gamma_rom
    import panel_seq_pkg::*;
#(
    parameter int LEVELS = GAMMA_LEVELS,
    parameter int NPARAM = GAMMA_NPARAM
) (
    input  logic [LVL_W-1:0] level,
    input  logic [POS_W-1:0] pos,
    output logic [7:0]       data
);

    logic [7:0] rom_q [LEVELS][NPARAM];

    for (genvar l = 0; l < LEVELS; l++) begin : g_lvl
        for (genvar p = 0; p < NPARAM; p++) begin : g_pos
            assign rom_q[l][p] = 8'((GAMMA_BASE + (p + 1) * GAMMA_POS_INC
                                     + l * GAMMA_LVL_INC) % 256);
        end
    end

    // Guarded table read.
    always_comb begin
        data = '0;
        if (int'(level) < LEVELS && pos != '0 && int'(pos) <= NPARAM)
            data = rom_q[level][pos - POS_W'(1)];
    end

endmodule

// File: rtl/panel_cmd_emitter.sv
`timescale 1ns/1ps
// Walks the command steps of one program. Each command goes out byte by
// byte on a valid/ready stream, and the emitter waits for the writer's done
// pulse after each command. A writer error ends the program early. Program
// and level are latched at start.
module panel_cmd_emitter
    import panel_seq_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  prog_e            prog,
    input  logic [LVL_W-1:0] level,
    input  logic             wr_ready,
    input  logic             wr_done,
    input  logic             wr_err,
    output logic             wr_valid,
    output logic [7:0]       wr_byte,
    output logic             wr_dc,
    output logic             wr_last,
    output logic             done,
    output logic             err
);

    typedef enum logic [1:0] {E_IDLE, E_BYTE, E_WAIT} est_e;

    est_e              es_q;
    prog_e             prog_q;
    logic [LVL_W-1:0]  lvl_q;
    logic [STEP_W-1:0] step_q;
    logic [POS_W-1:0]  pos_q;
    step_t             cur;
    logic [7:0]        gam_byte;
    logic [7:0]        par_byte;

    assign cur = step_lookup(prog_q, step_q);

    panel_gamma_rom u_rom (
        .level (lvl_q),
        .pos   (pos_q),
        .data  (gam_byte)
    );

    // Select the parameter byte for the current position.
    always_comb begin
        case (cur.kind)
            PK_GAMMA:  par_byte = gam_byte;
            PK_COMMIT: par_byte = GAMMA_COMMIT;
            default:   par_byte = cfg_param(cur.opcode, pos_q);
        endcase
    end

    assign wr_valid = (es_q == E_BYTE);
    assign wr_dc    = (pos_q != '0);
    assign wr_last  = (pos_q == cur.nparam);
    assign wr_byte  = wr_dc ? par_byte : cur.opcode;

    // Step and byte sequencing with the writer handshake.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            es_q   <= E_IDLE;
            prog_q <= PRG_INIT;
            lvl_q  <= '0;
            step_q <= '0;
            pos_q  <= '0;
            done   <= 1'b0;
            err    <= 1'b0;
        end else begin
            done <= 1'b0;
            case (es_q)
                E_IDLE: begin
                    if (start) begin
                        prog_q <= prog;
                        lvl_q  <= level;
                        step_q <= '0;
                        pos_q  <= '0;
                        err    <= 1'b0;
                        es_q   <= E_BYTE;
                    end
                end
                E_BYTE: begin
                    if (wr_ready) begin
                        if (wr_last) es_q  <= E_WAIT;
                        else         pos_q <= pos_q + POS_W'(1);
                    end
                end
                default: begin
                    if (wr_done) begin
                        if (wr_err || cur.last) begin
                            done <= 1'b1;
                            err  <= wr_err;
                            es_q <= E_IDLE;
                        end else begin
                            step_q <= step_q + STEP_W'(1);
                            pos_q  <= '0;
                            es_q   <= E_BYTE;
                        end
                    end
                end
            endcase
        end
    end

endmodule

// File: rtl/panel_seq_ctrl.sv
`timescale 1ns/1ps
// Panel power and enable sequencer, top level. Accepts one request at a
// time and orders the supplies, the reset and the command programs, with
// fixed waits counted in clock cycles. Assumes request inputs are
// synchronous single-cycle pulses.
module panel_seq_ctrl
    import panel_seq_pkg::*;
#(
    parameter int CYC_PER_MS    = 125000,
    parameter int T_SUPPLY_MS   = 25,
    parameter int T_RESET_MS    = 120,
    parameter int T_SLEEP_MS    = 200,
    parameter int DEFAULT_LEVEL = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_prepare,
    input  logic             req_enable,
    input  logic             req_disable,
    input  logic             req_unprepare,
    input  logic             lvl_set,
    input  logic [LVL_W-1:0] lvl_value,
    output logic [1:0]       sup_en,
    output logic             panel_rst,
    output logic             bl_en,
    output logic             prepared,
    output logic             enabled,
    output logic             busy,
    output logic             wr_valid,
    output logic [7:0]       wr_byte,
    output logic             wr_dc,
    output logic             wr_last,
    input  logic             wr_ready,
    input  logic             wr_done,
    input  logic             wr_err
);

    localparam int SUPPLY_CYC = T_SUPPLY_MS * CYC_PER_MS;
    localparam int RESET_CYC  = T_RESET_MS * CYC_PER_MS;
    localparam int SLEEP_CYC  = T_SLEEP_MS * CYC_PER_MS;
    localparam int MAX_CYC    = (SUPPLY_CYC > RESET_CYC)
                              ? ((SUPPLY_CYC > SLEEP_CYC) ? SUPPLY_CYC : SLEEP_CYC)
                              : ((RESET_CYC > SLEEP_CYC) ? RESET_CYC : SLEEP_CYC);
    localparam int CNT_W      = $clog2(MAX_CYC + 1);

    typedef enum logic [2:0] {
        ST_IDLE, ST_PU_SUPPLY, ST_PU_RESET, ST_SEND, ST_PD_RESET, ST_SLEEP_WAIT
    } state_e;

    state_e           state_q;
    prog_e            prog_q;
    logic [LVL_W-1:0] lvl_q;
    logic             tmr_go;
    logic [CNT_W-1:0] tmr_load;
    logic             tmr_fire;
    logic             em_go;
    logic             em_done;
    logic             em_err;
    logic             take_unprep;
    logic             take_disable;
    logic             take_prepare;
    logic             take_enable;
    logic             take_level;

    assign busy = (state_q != ST_IDLE);

    // Pick the one eligible request by fixed priority.
    always_comb begin
        take_unprep  = 1'b0;
        take_disable = 1'b0;
        take_prepare = 1'b0;
        take_enable  = 1'b0;
        take_level   = 1'b0;
        if (req_unprepare && prepared)                 take_unprep  = 1'b1;
        else if (req_disable && enabled)               take_disable = 1'b1;
        else if (req_prepare && !prepared)             take_prepare = 1'b1;
        else if (req_enable && prepared && !enabled)   take_enable  = 1'b1;
        else if (lvl_set && int'(lvl_value) < GAMMA_LEVELS) take_level = 1'b1;
    end

    panel_ms_timer #(
        .CNT_W (CNT_W)
    ) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .go    (tmr_go),
        .load  (tmr_load),
        .fire  (tmr_fire)
    );

    panel_cmd_emitter u_emit (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (em_go),
        .prog     (prog_q),
        .level    (lvl_q),
        .wr_ready (wr_ready),
        .wr_done  (wr_done),
        .wr_err   (wr_err),
        .wr_valid (wr_valid),
        .wr_byte  (wr_byte),
        .wr_dc    (wr_dc),
        .wr_last  (wr_last),
        .done     (em_done),
        .err      (em_err)
    );

    // Main life-cycle state machine.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= ST_IDLE;
            prog_q    <= PRG_INIT;
            lvl_q     <= LVL_W'(DEFAULT_LEVEL);
            sup_en    <= 2'b00;
            panel_rst <= 1'b1;
            bl_en     <= 1'b0;
            prepared  <= 1'b0;
            enabled   <= 1'b0;
            tmr_go    <= 1'b0;
            tmr_load  <= '0;
            em_go     <= 1'b0;
        end else begin
            tmr_go <= 1'b0;
            em_go  <= 1'b0;
            case (state_q)
                ST_IDLE: begin
                    if (take_unprep) begin
                        bl_en     <= 1'b0;
                        panel_rst <= 1'b1;
                        tmr_go    <= 1'b1;
                        tmr_load  <= CNT_W'(RESET_CYC);
                        state_q   <= ST_PD_RESET;
                    end else if (take_disable) begin
                        bl_en   <= 1'b0;
                        prog_q  <= PRG_SLEEP;
                        em_go   <= 1'b1;
                        state_q <= ST_SEND;
                    end else if (take_prepare) begin
                        sup_en   <= 2'b11;
                        tmr_go   <= 1'b1;
                        tmr_load <= CNT_W'(SUPPLY_CYC);
                        state_q  <= ST_PU_SUPPLY;
                    end else if (take_enable) begin
                        prog_q  <= PRG_ON;
                        em_go   <= 1'b1;
                        state_q <= ST_SEND;
                    end else if (take_level) begin
                        lvl_q <= lvl_value;
                        if (prepared) begin
                            prog_q  <= PRG_GAMMA;
                            em_go   <= 1'b1;
                            state_q <= ST_SEND;
                        end
                    end
                end
                ST_PU_SUPPLY: begin
                    if (tmr_fire) begin
                        panel_rst <= 1'b0;
                        tmr_go    <= 1'b1;
                        tmr_load  <= CNT_W'(RESET_CYC);
                        state_q   <= ST_PU_RESET;
                    end
                end
                ST_PU_RESET: begin
                    if (tmr_fire) begin
                        prog_q  <= PRG_INIT;
                        em_go   <= 1'b1;
                        state_q <= ST_SEND;
                    end
                end
                ST_SEND: begin
                    if (em_done) begin
                        case (prog_q)
                            PRG_INIT: begin
                                if (em_err) begin
                                    panel_rst <= 1'b1;
                                    tmr_go    <= 1'b1;
                                    tmr_load  <= CNT_W'(RESET_CYC);
                                    state_q   <= ST_PD_RESET;
                                end else begin
                                    prepared <= 1'b1;
                                    state_q  <= ST_IDLE;
                                end
                            end
                            PRG_ON: begin
                                bl_en   <= 1'b1;
                                enabled <= 1'b1;
                                state_q <= ST_IDLE;
                            end
                            PRG_SLEEP: begin
                                tmr_go   <= 1'b1;
                                tmr_load <= CNT_W'(SLEEP_CYC);
                                state_q  <= ST_SLEEP_WAIT;
                            end
                            default: state_q <= ST_IDLE;
                        endcase
                    end
                end
                ST_PD_RESET: begin
                    if (tmr_fire) begin
                        sup_en   <= 2'b00;
                        prepared <= 1'b0;
                        enabled  <= 1'b0;
                        state_q  <= ST_IDLE;
                    end
                end
                ST_SLEEP_WAIT: begin
                    if (tmr_fire) begin
                        enabled <= 1'b0;
                        state_q <= ST_IDLE;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/panel_seq_ctrl_chk.sv
`timescale 1ns/1ps
// Property checker for the panel sequencer, bound to the top module.
module panel_seq_ctrl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [1:0] sup_en,
    input logic       panel_rst,
    input logic       bl_en,
    input logic       prepared,
    input logic       enabled,
    input logic       busy,
    input logic       wr_valid,
    input logic [7:0] wr_byte,
    input logic       wr_dc,
    input logic       wr_ready
);

    assert_supplies_paired_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (sup_en == 2'b00) || (sup_en == 2'b11));

    assert_reset_while_unpowered_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (sup_en != 2'b11) |-> panel_rst);

    assert_backlight_needs_enabled_R6: assert property (@(posedge clk) disable iff (!rst_n)
        bl_en |-> (enabled && prepared));

    assert_enabled_needs_prepared_R4: assert property (@(posedge clk) disable iff (!rst_n)
        enabled |-> prepared);

    assert_stream_only_when_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid |-> busy);

    assert_byte_held_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && !wr_ready) |=> (wr_valid && $stable(wr_byte) && $stable(wr_dc)));

endmodule

bind panel_seq_ctrl panel_seq_ctrl_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .sup_en    (sup_en),
    .panel_rst (panel_rst),
    .bl_en     (bl_en),
    .prepared  (prepared),
    .enabled   (enabled),
    .busy      (busy),
    .wr_valid  (wr_valid),
    .wr_byte   (wr_byte),
    .wr_dc     (wr_dc),
    .wr_ready  (wr_ready)
);

// File: tb/panel_seq_ctrl_bench.sv
`timescale 1ns/1ps
module panel_seq_ctrl_bench;

    localparam int MS = 4;
    localparam int WD_LIMIT = 150000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       req_prepare = 1'b0, req_enable = 1'b0, req_disable = 1'b0, req_unprepare = 1'b0;
    logic       lvl_set = 1'b0;
    logic [3:0] lvl_value = 4'd0;
    logic [1:0] sup_en;
    logic       panel_rst, bl_en, prepared, enabled, busy;
    logic       wr_valid, wr_dc, wr_last;
    logic [7:0] wr_byte;
    logic       wr_ready = 1'b0, wr_done = 1'b0, wr_err = 1'b0;

    panel_seq_ctrl #(.CYC_PER_MS(MS)) u_panel_seq_ctrl (
        .clk(clk), .rst_n(rst_n),
        .req_prepare(req_prepare), .req_enable(req_enable),
        .req_disable(req_disable), .req_unprepare(req_unprepare),
        .lvl_set(lvl_set), .lvl_value(lvl_value),
        .sup_en(sup_en), .panel_rst(panel_rst), .bl_en(bl_en),
        .prepared(prepared), .enabled(enabled), .busy(busy),
        .wr_valid(wr_valid), .wr_byte(wr_byte), .wr_dc(wr_dc), .wr_last(wr_last),
        .wr_ready(wr_ready), .wr_done(wr_done), .wr_err(wr_err)
    );

    always #4 clk = ~clk;

    int tests = 0, fails = 0, cyc = 0, wd = 0;
    logic [7:0] blog [0:4095];
    int cstart [0:255];
    int clen [0:255];
    int nbytes = 0, ncmd = 0, curlen = 0, dcnt = 0, dc_bad = 0;
    int err_at = -1;
    bit stall = 1'b0, busy_seen = 1'b0, first_arm = 1'b0;
    int t_sup_on = 0, t_sup_off = 0, t_rst_fall = 0, t_rst_rise = 0;
    int t_first_v = 0, t_done = 0, t_en_fall = 0, t_bl_rise = 0;
    logic [1:0] p_sup = 2'b00;
    logic p_rst = 1'b1, p_en = 1'b0, p_bl = 1'b0;

    always @(posedge clk) begin
        cyc++;
        wd++;
        if (wd == WD_LIMIT) begin
            fails++;
            tests++;
            $display("FAIL watchdog: run hung, actual %0d cycles expected < %0d", wd, WD_LIMIT);
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    // Writer model and edge monitor, away from the active edge.
    always @(negedge clk) begin
        bit nr;
        wr_done = 1'b0;
        wr_err  = 1'b0;
        if (dcnt == 1) begin
            wr_done = 1'b1;
            wr_err  = (ncmd - 1 == err_at);
            t_done  = cyc;
            dcnt    = 0;
        end else if (dcnt > 1) dcnt--;
        nr = !stall || (cyc % 3 != 0);
        wr_ready = nr;
        if (wr_valid && first_arm) begin t_first_v = cyc; first_arm = 1'b0; end
        if (wr_valid && nr) begin
            if (curlen == 0) cstart[ncmd] = nbytes;
            if (wr_dc != (curlen != 0)) dc_bad++;
            blog[nbytes] = wr_byte;
            nbytes++;
            curlen++;
            if (wr_last) begin
                clen[ncmd] = curlen;
                ncmd++;
                curlen = 0;
                dcnt = 2;
            end
        end
        if (busy) busy_seen = 1'b1;
        if (sup_en == 2'b11 && p_sup != 2'b11) t_sup_on = cyc;
        if (sup_en == 2'b00 && p_sup != 2'b00) t_sup_off = cyc;
        if (!panel_rst && p_rst) t_rst_fall = cyc;
        if (panel_rst && !p_rst) t_rst_rise = cyc;
        if (!enabled && p_en) t_en_fall = cyc;
        if (bl_en && !p_bl) t_bl_rise = cyc;
        p_sup = sup_en; p_rst = panel_rst; p_en = enabled; p_bl = bl_en;
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic chk_range(input string tag, input int act, input int lo, input int hi);
        chk(act >= lo && act <= hi, tag, act, lo);
    endtask

    // kind: 0 = config rule, 1 = gamma rule, 2 = commit
    function automatic logic [7:0] exp_byte(input logic [7:0] op, input int kind, input int lvl, input int i);
        if (i == 0) return op;
        if (kind == 1) return 8'((32 + 7 * i + 11 * lvl) % 256);
        if (kind == 2) return 8'h01;
        return op ^ 8'((i * 19) % 256);
    endfunction

    task automatic chk_cmd(input int idx, input logic [7:0] op, input int np, input int kind,
                           input int lvl, input string tag);
        int bad = -1;
        if (idx >= ncmd) begin chk(0, tag, ncmd, idx + 1); return; end
        if (clen[idx] != np + 1) begin chk(0, tag, clen[idx], np + 1); return; end
        for (int i = 0; i <= np; i++)
            if (bad < 0 && blog[cstart[idx] + i] != exp_byte(op, kind, lvl, i)) bad = i;
        if (bad >= 0) chk(0, tag, blog[cstart[idx] + bad], exp_byte(op, kind, lvl, bad));
        else chk(1, tag, 0, 0);
    endtask

    task automatic chk_init(input int base, input int lvl, input string tag);
        logic [7:0] ops [8] = '{8'hF8, 8'hF2, 8'hF7, 8'hFA, 8'hFA, 8'hF6, 8'hB1, 8'h11};
        int nps [8] = '{14, 5, 3, 22, 1, 3, 1, 0};
        int kinds [8] = '{0, 0, 0, 1, 2, 0, 0, 0};
        for (int k = 0; k < 8; k++) chk_cmd(base + k, ops[k], nps[k], kinds[k], lvl, tag);
    endtask

    // which: bit0 prepare, bit1 enable, bit2 disable, bit3 unprepare, bit4 level
    task automatic pulse(input int which, input int lvl);
        @(negedge clk);
        busy_seen     = 1'b0;
        req_prepare   = which[0];
        req_enable    = which[1];
        req_disable   = which[2];
        req_unprepare = which[3];
        lvl_set       = which[4];
        lvl_value     = 4'(lvl);
        @(negedge clk);
        req_prepare = 0; req_enable = 0; req_disable = 0; req_unprepare = 0; lvl_set = 0;
    endtask

    task automatic settle();
        while (busy) @(negedge clk);
        repeat (4) @(negedge clk);
    endtask

    initial begin
        int base;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(sup_en == 2'b00 && panel_rst, "R1 supplies off and reset high", {sup_en, panel_rst}, 1);
        chk(!bl_en && !prepared && !enabled, "R1 flags low", {bl_en, prepared, enabled}, 0);
        chk(!busy && !wr_valid, "R1 idle stream", {busy, wr_valid}, 0);

        // R6 enable ignored when not prepared; R9 unprepare ignored when not prepared
        pulse(2, 0); settle();
        chk(ncmd == 0 && !enabled && !busy_seen, "R6 enable while unprepared", ncmd, 0);
        pulse(8, 0); settle();
        chk(!busy_seen && sup_en == 2'b00 && panel_rst, "R9 unprepare while unprepared", busy_seen, 0);

        // R2/R3/R8/R11 first prepare with a stalling writer, default level
        stall = 1'b1; first_arm = 1'b1;
        pulse(1, 0); settle();
        chk_range("R2 supply to reset release", t_rst_fall - t_sup_on, 100, 103);
        chk_range("R2 reset release to first command", t_first_v - t_rst_fall, 480, 484);
        chk_init(0, 10, "R3 init sequence (R8 default level 10)");
        chk(prepared && !enabled && sup_en == 2'b11 && !panel_rst, "R3 prepared flag", prepared, 1);
        chk(dc_bad == 0, "R11 opcode/parameter marking under stalls", dc_bad, 0);
        stall = 1'b0;

        // R4 repeat prepare ignored
        base = ncmd;
        pulse(1, 0); settle();
        chk(ncmd == base && !busy_seen, "R4 repeat prepare", ncmd, base);

        // R8 sweep all valid levels, then the invalid ones
        for (int l = 0; l <= 10; l++) begin
            base = ncmd;
            pulse(16, l); settle();
            chk(ncmd == base + 2, "R8 gamma command count", ncmd - base, 2);
            chk_cmd(base, 8'hFA, 22, 1, l, "R8 gamma bytes");
            chk_cmd(base + 1, 8'hFA, 1, 2, l, "R8 gamma commit");
        end
        base = ncmd;
        for (int l = 11; l <= 15; l++) begin
            pulse(16, l); settle();
        end
        chk(ncmd == base && !busy_seen, "R8 out-of-range levels ignored", ncmd, base);

        // R6 enable
        base = ncmd;
        pulse(2, 0); settle();
        chk_cmd(base, 8'h29, 0, 0, 0, "R6 display-on command");
        chk(bl_en && enabled, "R6 backlight and enabled set", {bl_en, enabled}, 3);
        chk(t_bl_rise > t_done, "R6 backlight after display-on done", t_bl_rise, t_done + 1);
        base = ncmd;
        pulse(2, 0); settle();
        chk(ncmd == base && !busy_seen, "R6 repeat enable", ncmd, base);

        // R12 disable beats brightness; R7 timing; R10 request during busy dropped
        base = ncmd;
        pulse(20, 3);
        chk(!bl_en && busy, "R7 backlight drops at once", bl_en, 0);
        repeat (20) @(negedge clk);
        pulse(8, 0);
        settle();
        chk(ncmd == base + 1, "R12 only the disable acts", ncmd - base, 1);
        chk_cmd(base, 8'h10, 0, 0, 0, "R7 enter-sleep command");
        chk_range("R7 sleep wait before enabled clears", t_en_fall - t_done, 800, 808);
        chk(prepared && sup_en == 2'b11 && !enabled, "R10 unprepare during busy dropped", prepared, 1);

        // R13 error on gamma write skips commit
        base = ncmd; err_at = ncmd;
        pulse(16, 5); settle();
        err_at = -1;
        chk(ncmd == base + 1, "R13 commit skipped after error", ncmd - base, 1);

        // R9 unprepare
        pulse(8, 0); settle();
        chk_range("R9 reset to supply off", t_sup_off - t_rst_rise, 480, 484);
        chk(!prepared && !enabled && panel_rst && sup_en == 2'b00, "R9 powered down", prepared, 0);

        // R8 level stored while unprepared; R12 prepare beats enable
        base = ncmd;
        pulse(16, 2); settle();
        chk(ncmd == base, "R8 no write while unprepared", ncmd, base);
        pulse(3, 0); settle();
        chk_init(base, 2, "R12 prepare wins, R8 stored level used");
        chk(prepared && !enabled && !bl_en, "R12 enable not taken", enabled, 0);
        pulse(8, 0); settle();

        // R5 init failure on the third command
        base = ncmd; err_at = ncmd + 2;
        pulse(1, 0); settle();
        err_at = -1;
        chk(ncmd == base + 3, "R5 remaining init commands skipped", ncmd - base, 3);
        chk(!prepared && sup_en == 2'b00 && panel_rst, "R5 powered down after failure", prepared, 0);
        chk_range("R5 reset to supply off", t_sup_off - t_rst_rise, 480, 484);

        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule